// File: doc/BRIEF.md
# Four-Phase Timing Generator

This block turns one input clock into the internal timing of a small serial-protocol controller core. A twisted-ring counter with `NUM_PH/2` stages steps through `NUM_PH` states on rising clock edges. One two-input AND gate per state decodes it into a phase. Each decoded phase is then captured by a register clocked on the falling edge. The captured phases therefore start half a clock after the decode and hold for one full clock. Each captured phase overlaps the decode of its own state and the decode of the next state. Those two overlaps split the phase into an early half-slot and a late half-slot.

The core uses the half-slots as update enables in a fixed order:

| Half-slot | Point in the cycle | Update enable | What it updates |
|---|---|---|---|
| 0 | phase 0 | `pc_upd_o` | program counter |
| 1 | phase 0.5 | `ram_wr_o` | RAM write |
| 2 | phase 1 | `carry_upd_o` | serial output bit, bank-select holding bit, adder result register |
| 3 | phase 1.5 | `ram_lat_o` | RAM read-data register |
| 4 | phase 2 | `acc_upd_o` | RAM address register and accumulator |
| 6 | phase 3 | `rom_upd_o` | ROM word fetch and bank-select transfer |

A cycle strobe marks the clock period in which the ring holds its start state.

Top module: `johnson_phase_gen`

## Requirements
- R1: While `rst_i` is high, sampled after a falling edge, `phase_o` is 0001 (bit 0 only), `slot_o` has only bit 0 set and `cycle_o` is 1.
- R2: The ring advances one state per rising edge once reset is released. `cycle_o` is 1 exactly in the clock periods where the number of rising edges since release is a multiple of `NUM_PH`, which is once every `NUM_PH` clocks.
- R3: `phase_o` changes only on falling edges. After the n-th rising edge since release, `phase_o` has only bit ((n-1) mod `NUM_PH`) set. After the following falling edge it has only bit (n mod `NUM_PH`) set. Phase 0 is therefore the first phase after release.
- R4: Exactly one bit of `phase_o` is high at every sample point outside reset.
- R5: `slot_o` is one-hot with 2·`NUM_PH` bits. Bit 2k is high from the falling edge that starts phase k to the next rising edge. Bit 2k+1 is high from that rising edge to the next falling edge.
- R6: `pc_upd_o` equals `slot_o[0]` and `ram_wr_o` equals `slot_o[1]`, so the RAM write enable always directly follows the program-counter enable.
- R7: `carry_upd_o` equals `slot_o[2]` (phase 1) and `ram_lat_o` equals `slot_o[3]` (phase 1.5).
- R8: `acc_upd_o` equals `slot_o[4]` (phase 2) and `rom_upd_o` equals `slot_o[6]` (phase 3). In half-slots 5 and 7 all six update enables are 0.
- R9: Reset applied mid-run, at any ring position, returns the ring to its start state at the next rising edge (`cycle_o` = 1). It returns `phase_o` to 0001 at the following falling edge. After release the sequence restarts as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; the ring uses the rising edge, the phase registers the falling edge |
| rst_i | input | 1 | Synchronous active-high reset |
| phase_o | output | NUM_PH | Phases captured on the falling edge, one-hot |
| slot_o | output | 2*NUM_PH | Half-clock slots, one-hot |
| cycle_o | output | 1 | High while the ring is in its start state |
| pc_upd_o | output | 1 | Program-counter update enable (slot 0) |
| ram_wr_o | output | 1 | RAM write enable (slot 1) |
| carry_upd_o | output | 1 | Serial output bit, bank-select holding bit and adder result register update enable (slot 2) |
| ram_lat_o | output | 1 | RAM read-data register update enable (slot 3) |
| acc_upd_o | output | 1 | RAM address register and accumulator update enable (slot 4) |
| rom_upd_o | output | 1 | ROM fetch and bank-select transfer enable (slot 6) |

## Verification
The ring result (`cycle_o`) is due in the same clock period as the rising edge that moves the ring. The captured phase is due only after the next falling edge, half a clock later. The half-slots and update enables are due on whichever edge came last.

The bench keeps a count of rising edges since reset release. It checks 1 ns after each rising edge, where the late slot of phase (n-1) must show. It checks again 1 ns after each falling edge, where the early slot of phase n must show.

Mid-run resets are issued at every ring position. After each one, the bench checks the start state at the first rising edge and the restored phase at the following falling edge.

// File: rtl/jpg_pkg.sv
package jpg_pkg;

    // Half-slot positions of each pipeline update inside one core cycle.
    localparam int SLOT_PC      = 0;  // phase 0
    localparam int SLOT_RAM_WR  = 1;  // phase 0.5
    localparam int SLOT_CARRY   = 2;  // phase 1
    localparam int SLOT_RAM_LAT = 3;  // phase 1.5
    localparam int SLOT_ACC     = 4;  // phase 2
    localparam int SLOT_ROM     = 6;  // phase 3

    typedef struct packed {
        logic pc;
        logic ram_wr;
        logic carry;
        logic ram_lat;
        logic acc;
        logic rom;
    } upd_t;

    // Index of the phase that follows phase k in a ring of n phases.
    function automatic int next_phase(input int k, input int n);
        return (k + 1) % n;
    endfunction

endpackage

// File: rtl/jpg_ring.sv
module jpg_ring #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Twisted ring: shift left, feed back the inverted top stage.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= {q[W-2:0], ~q[W-1]};
        end
    end

    assign q_o = q;
endmodule

// File: rtl/jpg_decode.sv
module jpg_decode #(
    parameter int NUM_PH = 4,
    localparam int W = NUM_PH / 2
) (
    input  logic [W-1:0]      q_i,
    output logic [NUM_PH-1:0] dec_o
);
    // One two-input gate per state, looking at the boundary between
    // the filled and the empty part of the ring.
    for (genvar k = 0; k < NUM_PH; k++) begin : g_gate
        if (k == 0) begin : g_empty
            assign dec_o[k] = ~q_i[W-1] & ~q_i[0];
        end else if (k < W) begin : g_fill
            assign dec_o[k] = q_i[k-1] & ~q_i[k];
        end else if (k == W) begin : g_full
            assign dec_o[k] = q_i[W-1] & q_i[0];
        end else begin : g_drain
            assign dec_o[k] = ~q_i[k-W-1] & q_i[k-W];
        end
    end
endmodule

// File: rtl/jpg_latch.sv
module jpg_latch #(
    parameter int NUM_PH = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_PH-1:0] dec_i,
    output logic [NUM_PH-1:0] ph_o
);
    localparam logic [NUM_PH-1:0] START = NUM_PH'(1);

    logic [NUM_PH-1:0] ph;

    // Captured on the falling edge: phases lag the decode by half a clock.
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            ph <= START;
        end else begin
            ph <= dec_i;
        end
    end

    assign ph_o = ph;
endmodule

// File: rtl/jpg_slots.sv
module jpg_slots
    import jpg_pkg::*;
#(
    parameter int NUM_PH = 4,
    localparam int NSLOT = 2 * NUM_PH
) (
    input  logic [NUM_PH-1:0] ph_i,
    input  logic [NUM_PH-1:0] dec_i,
    output logic [NSLOT-1:0]  slot_o,
    output upd_t              upd_o
);
    for (genvar k = 0; k < NUM_PH; k++) begin : g_half
        localparam int NXT = next_phase(k, NUM_PH);
        // Early half: captured phase k while the ring still decodes k.
        assign slot_o[2*k]   = ph_i[k] & dec_i[k];
        // Late half: captured phase k after the ring has moved on.
        assign slot_o[2*k+1] = ph_i[k] & dec_i[NXT];
    end

    always_comb begin
        upd_o.pc      = slot_o[SLOT_PC];
        upd_o.ram_wr  = slot_o[SLOT_RAM_WR];
        upd_o.carry   = slot_o[SLOT_CARRY];
        upd_o.ram_lat = slot_o[SLOT_RAM_LAT];
        upd_o.acc     = slot_o[SLOT_ACC];
        upd_o.rom     = slot_o[SLOT_ROM];
    end
endmodule

// File: rtl/johnson_phase_gen.sv
module johnson_phase_gen
    import jpg_pkg::*;
#(
    parameter int NUM_PH = 4  // even, at least 4
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    output logic [NUM_PH-1:0]     phase_o,
    output logic [2*NUM_PH-1:0]   slot_o,
    output logic                  cycle_o,
    output logic                  pc_upd_o,
    output logic                  ram_wr_o,
    output logic                  carry_upd_o,
    output logic                  ram_lat_o,
    output logic                  acc_upd_o,
    output logic                  rom_upd_o
);
    localparam int W = NUM_PH / 2;

    logic [W-1:0]      ring;
    logic [NUM_PH-1:0] dec;
    logic [NUM_PH-1:0] ph;
    upd_t              upd;

    jpg_ring #(.W(W)) u_ring (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .q_o   (ring)
    );

    jpg_decode #(.NUM_PH(NUM_PH)) u_dec (
        .q_i   (ring),
        .dec_o (dec)
    );

    jpg_latch #(.NUM_PH(NUM_PH)) u_lat (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .dec_i (dec),
        .ph_o  (ph)
    );

    jpg_slots #(.NUM_PH(NUM_PH)) u_slots (
        .ph_i   (ph),
        .dec_i  (dec),
        .slot_o (slot_o),
        .upd_o  (upd)
    );

    assign phase_o     = ph;
    assign cycle_o     = dec[0];
    assign pc_upd_o    = upd.pc;
    assign ram_wr_o    = upd.ram_wr;
    assign carry_upd_o = upd.carry;
    assign ram_lat_o   = upd.ram_lat;
    assign acc_upd_o   = upd.acc;
    assign rom_upd_o   = upd.rom;
endmodule

// File: rtl/johnson_phase_gen_chk.sv
module johnson_phase_gen_chk #(
    parameter int NUM_PH = 4
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic [NUM_PH-1:0]   phase_o,
    input logic [2*NUM_PH-1:0] slot_o,
    input logic                cycle_o,
    input logic                pc_upd_o,
    input logic                ram_wr_o
);
    logic armed;
    logic pc_prev;
    logic rst_q;

    always_ff @(posedge clk_i) begin
        armed   <= !rst_i;
        pc_prev <= !rst_i && pc_upd_o;
        rst_q   <= rst_i;
    end

    // R4
    phase_onehot_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        $countones(phase_o) == 1);

    // R5
    slot_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(slot_o) == 1);

    // R3
    phase_rotate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        armed |-> phase_o == {$past(phase_o[NUM_PH-2:0]), $past(phase_o[NUM_PH-1])});

    // R2
    cycle_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i && cycle_o) |=> !cycle_o);

    always @(negedge clk_i) begin
        if (!rst_i && pc_prev) begin
            // R6
            pc_then_wr_chk: assert (ram_wr_o)
                else $error("ram write slot did not follow pc slot");
        end
    end

    always @(posedge clk_i) begin
        if (rst_q) begin
            // R1
            reset_start_chk: assert (cycle_o)
                else $error("ring not in start state after reset edge");
        end
    end
endmodule

bind johnson_phase_gen johnson_phase_gen_chk #(.NUM_PH(NUM_PH)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .phase_o  (phase_o),
    .slot_o   (slot_o),
    .cycle_o  (cycle_o),
    .pc_upd_o (pc_upd_o),
    .ram_wr_o (ram_wr_o)
);

// File: tb/tb_johnson_phase_gen.sv
`timescale 1ns/1ps
module tb_johnson_phase_gen;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]   phase_o;
    logic [2*N-1:0] slot_o;
    logic cycle_o, pc_upd_o, ram_wr_o, carry_upd_o, ram_lat_o, acc_upd_o, rom_upd_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    johnson_phase_gen #(.NUM_PH(N)) dut (
        .clk_i(clk), .rst_i(rst), .phase_o(phase_o), .slot_o(slot_o),
        .cycle_o(cycle_o), .pc_upd_o(pc_upd_o), .ram_wr_o(ram_wr_o),
        .carry_upd_o(carry_upd_o), .ram_lat_o(ram_lat_o),
        .acc_upd_o(acc_upd_o), .rom_upd_o(rom_upd_o)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Check every output for the half-slot s.
    task automatic check_slot(input int s, input int cyc_exp);
        check("R3 phase", int'(phase_o), 1 << (s / 2));
        check("R4 onehot", $countones(phase_o), 1);
        check("R5 slot", int'(slot_o), 1 << s);
        check("R2 cycle", int'(cycle_o), cyc_exp);
        check("R6 pc", int'(pc_upd_o), int'(s == 0));
        check("R6 ramwr", int'(ram_wr_o), int'(s == 1));
        check("R7 carry", int'(carry_upd_o), int'(s == 2));
        check("R7 ramlat", int'(ram_lat_o), int'(s == 3));
        check("R8 acc", int'(acc_upd_o), int'(s == 4));
        check("R8 rom", int'(rom_upd_o), int'(s == 6));
        if (s == 5 || s == 7)
            check("R8 idle", int'({pc_upd_o, ram_wr_o, carry_upd_o, ram_lat_o,
                                   acc_upd_o, rom_upd_o}), 0);
    endtask

    // Entered 1 ns after a falling edge with reset just released.
    task automatic sweep(input int ncyc);
        for (int n = 1; n <= ncyc; n++) begin
            @(posedge clk); #1;
            check_slot(2 * ((n - 1) % N) + 1, int'(n % N == 0));
            @(negedge clk); #1;
            check_slot(2 * (n % N), int'(n % N == 0));
        end
    endtask

    task automatic mid_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        check("R9 ring start", int'(cycle_o), 1);
        @(negedge clk); #1;
        check("R9 phase start", int'(phase_o), 1);
        check("R9 slot start", int'(slot_o), 1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 phase", int'(phase_o), 1);
        check("R1 slot", int'(slot_o), 1);
        check("R1 cycle", int'(cycle_o), 1);
        rst = 1'b0;
        sweep(6 * N);
        for (int p = 0; p < 2 * N; p++) begin
            sweep(p);
            mid_reset();
        end
        sweep(2 * N);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule